// File: doc/BRIEF.md
# Gated Pulse Width Counter

This block times a slow digital Gate signal against a faster Source signal. It counts Source rising edges while Gate is high and while Gate is low, which gives one high count (H) and one low count (L) for each Gate pulse. All three inputs (Gate, Source and an external sample strobe) are asynchronous. Each one passes through a two-flop synchronizer and an edge detector on the system clock.

A mode input picks one of three capture disciplines:
- **Single:** one pulse is measured and its pair is held in an output register.
- **Per-edge:** every Gate transition writes the count of the phase that just ended.
- **Sampled:** every sample strobe writes the pair of the most recently finished pulse.

A polarity input picks whether a pulse is taken as high-then-low or low-then-high. Writes leave through a single-cycle write strobe towards an external FIFO, which answers with a full flag. Dropping the arm input returns the block to its idle state.

Top module: `gate_pulse_meter`

## Requirements
- R1: Gate, Source and the sample strobe are each synchronized with two flops. A phase count equals the number of Source rising edges seen while that Gate phase lasted.
- R2: After arm rises, Gate edges of the non-starting kind and Source edges are ignored. Measurement begins only at the first Gate edge of the selected starting kind.
- R3: With `start_low`=0, a rising Gate edge starts a pulse, and the pulse is the high phase followed by the low phase. With `start_low`=1, a falling edge starts it, and the pulse is the low phase followed by the high phase.
- R4: With mode 0 (single), the first completed pulse loads `pair_h`/`pair_l` and sets `pair_valid`. Later pulses change neither while arm stays high. Mode 0 never writes to the FIFO.
- R5: With mode 1 (per-edge), every Gate edge after the start writes the ended phase's count. The count goes in `fifo_data[W-1:0]`, with the upper W bits zero. `fifo_high`=1 when a high phase ended and 0 when a low phase ended. The starting edge itself writes nothing.
- R6: With mode 2 (sampled), each rising sample strobe writes H in `fifo_data[2W-1:W]` and L in `fifo_data[W-1:0]`, taken from the last completed pulse. Strobes that come before any pulse has completed write nothing.
- R7: In mode 2, `fifo_repeat`=1 when no pulse has completed since the previous write, and 0 otherwise.
- R8: A phase count stops at 2^W-1 instead of wrapping, and `sat_flag` is set and stays set.
- R9: A write requested while `fifo_full`=1 is dropped (no `fifo_wr`), and `overrun_flag` is set and stays set.
- R10: With arm low, the block clears `pair_valid`, `pair_h`, `pair_l`, `sat_flag` and `overrun_flag`, and makes no writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Enables measurement; low clears the block |
| mode | input | 2 | 0 single, 1 per-edge, 2 sampled, 3 no capture |
| start_low | input | 1 | 0: high phase first, 1: low phase first |
| gate_in | input | 1 | Asynchronous Gate signal being timed |
| src_in | input | 1 | Asynchronous Source tick signal |
| smp_in | input | 1 | Asynchronous sample strobe (mode 2) |
| fifo_full | input | 1 | FIFO cannot accept a write |
| fifo_wr | output | 1 | One-cycle write strobe |
| fifo_data | output | 2*W | Written count or H/L pair |
| fifo_high | output | 1 | Per-edge mode: written count was a high phase |
| fifo_repeat | output | 1 | Sampled mode: written pair was already reported |
| pair_h | output | W | Latched high count (single mode) |
| pair_l | output | W | Latched low count (single mode) |
| pair_valid | output | 1 | Latched pair holds a measurement |
| sat_flag | output | 1 | Sticky: a count saturated |
| overrun_flag | output | 1 | Sticky: a write was dropped while full |

## Verification
The assertions guard several properties on every cycle:
- no write while full;
- the sticky overrun and saturation flags;
- the cleared state one cycle after arm falls;
- a latched single-mode pair that does not move.

Only the directed scenarios can show that the counts are right for a given Gate/Source pattern. The same holds for the wait for the correct starting edge, the H/L ordering under both polarities, the per-edge phase tagging, and the repeat marking of sampled writes.

// File: rtl/gpm_pkg.sv
package gpm_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE  = 2'd0,
        MODE_EDGE    = 2'd1,
        MODE_SAMPLED = 2'd2,
        MODE_NONE    = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RUN,
        ST_HOLD
    } state_e;

    localparam int SYNC_LANES = 4;
    localparam int LANE_GATE_R = 0;
    localparam int LANE_GATE_F = 1;
    localparam int LANE_SRC    = 2;
    localparam int LANE_SMP    = 3;

endpackage

// File: rtl/gpm_sync_edge.sv
module gpm_sync_edge #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise
);
    // Per lane: two synchronizer flops plus one history flop.
    for (genvar i = 0; i < N; i++) begin : g_lane
        logic s1, s2, s3;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
                s3 <= 1'b0;
            end else begin
                s1 <= din[i];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign rise[i] = s2 & ~s3;
    end
endmodule

// File: rtl/gpm_core.sv
module gpm_core
    import gpm_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           arm,
    input  logic [1:0]     mode,
    input  logic           start_low,
    input  logic           g_rise,
    input  logic           g_fall,
    input  logic           s_rise,
    input  logic           k_rise,
    output logic           req,
    output logic [2*W-1:0] req_data,
    output logic           req_high,
    output logic           req_rep,
    output logic [W-1:0]   pair_h,
    output logic [W-1:0]   pair_l,
    output logic           pair_valid,
    output logic           sat_flag
);
    localparam logic [W-1:0] CMAX = '1;

    typedef struct packed {
        logic [W-1:0] hi;
        logic [W-1:0] lo;
    } pair_t;

    state_e       st;
    mode_e        md;
    logic [W-1:0] cnt, h_hold, l_hold;
    pair_t        last_pair, new_pair;
    logic         have_pair, fresh;
    logic         running, g_edge, st_edge, done, k_push;

    assign md       = mode_e'(mode);
    assign running  = (st == ST_RUN);
    assign g_edge   = g_rise | g_fall;
    assign st_edge  = start_low ? g_fall : g_rise;
    assign done     = running && st_edge;
    assign new_pair.hi = g_fall ? cnt : h_hold;
    assign new_pair.lo = g_rise ? cnt : l_hold;
    assign k_push   = (md == MODE_SAMPLED) && k_rise && (done || have_pair);

    always_comb begin
        req      = 1'b0;
        req_data = '0;
        req_high = 1'b0;
        req_rep  = 1'b0;
        if (md == MODE_EDGE && running && g_edge) begin
            req      = 1'b1;
            req_data = {{W{1'b0}}, cnt};
            req_high = g_fall;
        end else if (k_push) begin
            req      = 1'b1;
            req_data = done ? new_pair : last_pair;
            req_rep  = !(done || fresh);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !arm) begin
            st         <= ST_IDLE;
            cnt        <= '0;
            h_hold     <= '0;
            l_hold     <= '0;
            last_pair  <= '0;
            have_pair  <= 1'b0;
            fresh      <= 1'b0;
            pair_h     <= '0;
            pair_l     <= '0;
            pair_valid <= 1'b0;
            sat_flag   <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: st <= ST_WAIT;
                ST_WAIT: begin
                    if (st_edge) begin
                        st  <= ST_RUN;
                        cnt <= s_rise ? W'(1) : '0;
                    end
                end
                ST_RUN: begin
                    if (g_edge) begin
                        cnt <= s_rise ? W'(1) : '0;
                        if (g_fall) h_hold <= cnt;
                        if (g_rise) l_hold <= cnt;
                        if (done) begin
                            last_pair <= new_pair;
                            have_pair <= 1'b1;
                            if (md == MODE_SINGLE) begin
                                pair_h     <= new_pair.hi;
                                pair_l     <= new_pair.lo;
                                pair_valid <= 1'b1;
                                st         <= ST_HOLD;
                            end
                        end
                    end else if (s_rise) begin
                        if (cnt == CMAX) sat_flag <= 1'b1;
                        else             cnt <= cnt + W'(1);
                    end
                end
                default: st <= st;
            endcase
            if (k_push)    fresh <= 1'b0;
            else if (done) fresh <= 1'b1;
        end
    end

    // R8
    sat_set_chk: assert property (@(posedge clk) disable iff (rst)
        (arm && running && s_rise && !g_edge && cnt == CMAX) |=> sat_flag);

    // R8
    sat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (sat_flag && arm) |=> sat_flag);

    // R4
    single_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pair_valid && arm) |=> (pair_valid && $stable(pair_h) && $stable(pair_l)));

    // R10
    disarm_core_chk: assert property (@(posedge clk) disable iff (rst)
        !arm |=> (!pair_valid && !sat_flag && pair_h == '0 && pair_l == '0));
endmodule

// File: rtl/gpm_wr_port.sv
module gpm_wr_port #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic          req,
    input  logic [DW-1:0] req_data,
    input  logic          req_high,
    input  logic          req_rep,
    input  logic          fifo_full,
    output logic          fifo_wr,
    output logic [DW-1:0] fifo_data,
    output logic          fifo_high,
    output logic          fifo_repeat,
    output logic          overrun_flag
);
    always_ff @(posedge clk) begin
        if (rst || !arm) begin
            fifo_wr      <= 1'b0;
            fifo_data    <= '0;
            fifo_high    <= 1'b0;
            fifo_repeat  <= 1'b0;
            overrun_flag <= 1'b0;
        end else begin
            fifo_wr <= req && !fifo_full;
            if (req && !fifo_full) begin
                fifo_data   <= req_data;
                fifo_high   <= req_high;
                fifo_repeat <= req_rep;
            end
            if (req && fifo_full) overrun_flag <= 1'b1;
        end
    end

    // R9
    no_write_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> $past(!fifo_full));

    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (overrun_flag && arm) |=> overrun_flag);

    // R10
    disarm_port_chk: assert property (@(posedge clk) disable iff (rst)
        !arm |=> (!fifo_wr && !overrun_flag));
endmodule

// File: rtl/gate_pulse_meter.sv
module gate_pulse_meter
    import gpm_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           arm,
    input  logic [1:0]     mode,
    input  logic           start_low,
    input  logic           gate_in,
    input  logic           src_in,
    input  logic           smp_in,
    input  logic           fifo_full,
    output logic           fifo_wr,
    output logic [2*W-1:0] fifo_data,
    output logic           fifo_high,
    output logic           fifo_repeat,
    output logic [W-1:0]   pair_h,
    output logic [W-1:0]   pair_l,
    output logic           pair_valid,
    output logic           sat_flag,
    output logic           overrun_flag
);
    localparam int DW = 2 * W;

    logic [SYNC_LANES-1:0] raw, rise;
    logic                  req, req_high, req_rep;
    logic [DW-1:0]         req_data;

    // A falling Gate edge is detected as a rise on an inverted lane.
    always_comb begin
        raw              = '0;
        raw[LANE_GATE_R] = gate_in;
        raw[LANE_GATE_F] = ~gate_in;
        raw[LANE_SRC]    = src_in;
        raw[LANE_SMP]    = smp_in;
    end

    gpm_sync_edge #(.N(SYNC_LANES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw),
        .rise (rise)
    );

    gpm_core #(.W(W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .arm        (arm),
        .mode       (mode),
        .start_low  (start_low),
        .g_rise     (rise[LANE_GATE_R]),
        .g_fall     (rise[LANE_GATE_F]),
        .s_rise     (rise[LANE_SRC]),
        .k_rise     (rise[LANE_SMP]),
        .req        (req),
        .req_data   (req_data),
        .req_high   (req_high),
        .req_rep    (req_rep),
        .pair_h     (pair_h),
        .pair_l     (pair_l),
        .pair_valid (pair_valid),
        .sat_flag   (sat_flag)
    );

    gpm_wr_port #(.DW(DW)) u_port (
        .clk          (clk),
        .rst          (rst),
        .arm          (arm),
        .req          (req),
        .req_data     (req_data),
        .req_high     (req_high),
        .req_rep      (req_rep),
        .fifo_full    (fifo_full),
        .fifo_wr      (fifo_wr),
        .fifo_data    (fifo_data),
        .fifo_high    (fifo_high),
        .fifo_repeat  (fifo_repeat),
        .overrun_flag (overrun_flag)
    );
endmodule

// File: tb/sim_gate_pulse_meter.sv
module sim_gate_pulse_meter;
    localparam int W = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic arm = 1'b0;
    logic [1:0] mode = 2'd0;
    logic start_low = 1'b0;
    logic gate_in = 1'b0, src_in = 1'b0, smp_in = 1'b0, fifo_full = 1'b0;
    logic fifo_wr, fifo_high, fifo_repeat, pair_valid, sat_flag, overrun_flag;
    logic [2*W-1:0] fifo_data;
    logic [W-1:0] pair_h, pair_l;

    int errors = 0;
    int checks = 0;
    int n_rec = 0;
    logic [2*W-1:0] rec_d [0:63];
    logic rec_h [0:63];
    logic rec_r [0:63];

    always #2.5 clk = ~clk;

    gate_pulse_meter #(.W(W)) u0 (
        .clk(clk), .rst(rst), .arm(arm), .mode(mode), .start_low(start_low),
        .gate_in(gate_in), .src_in(src_in), .smp_in(smp_in), .fifo_full(fifo_full),
        .fifo_wr(fifo_wr), .fifo_data(fifo_data), .fifo_high(fifo_high),
        .fifo_repeat(fifo_repeat), .pair_h(pair_h), .pair_l(pair_l),
        .pair_valid(pair_valid), .sat_flag(sat_flag), .overrun_flag(overrun_flag)
    );

    always @(negedge clk) begin
        if (fifo_wr && n_rec < 64) begin
            rec_d[n_rec] = fifo_data;
            rec_h[n_rec] = fifo_high;
            rec_r[n_rec] = fifo_repeat;
            n_rec = n_rec + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic phase(input logic lvl, input int n);
        gate_in = lvl;
        for (int i = 0; i < n; i++) begin
            cyc(3); src_in = 1'b1;
            cyc(3); src_in = 1'b0;
        end
        cyc(3);
    endtask

    task automatic sample();
        smp_in = 1'b1; cyc(4);
        smp_in = 1'b0; cyc(4);
    endtask

    task automatic disarm();
        arm = 1'b0; cyc(4);
        n_rec = 0;
    endtask

    task automatic t_reset();
        chk("R10 reset fifo_wr", int'(fifo_wr), 0);
        chk("R10 reset pair_valid", int'(pair_valid), 0);
        chk("R10 reset sat_flag", int'(sat_flag), 0);
        chk("R10 reset overrun_flag", int'(overrun_flag), 0);
    endtask

    task automatic t_single_high_first();
        mode = 2'd0; start_low = 1'b0; gate_in = 1'b0; cyc(5);
        arm = 1'b1; cyc(3);
        phase(1, 4); phase(0, 2); phase(1, 3); cyc(5);
        chk("R1 R3 single H", int'(pair_h), 4);
        chk("R1 R3 single L", int'(pair_l), 2);
        chk("R4 single valid", int'(pair_valid), 1);
        phase(0, 5); phase(1, 1); phase(0, 0); cyc(5);
        chk("R4 single H held", int'(pair_h), 4);
        chk("R4 single L held", int'(pair_l), 2);
        chk("R4 single no writes", n_rec, 0);
        disarm();
        chk("R10 disarm pair_valid", int'(pair_valid), 0);
        chk("R10 disarm pair_h", int'(pair_h), 0);
    endtask

    task automatic t_start_low();
        mode = 2'd0; start_low = 1'b1; gate_in = 1'b1; cyc(5);
        arm = 1'b1; cyc(3);
        phase(1, 2); phase(0, 3); phase(1, 5); phase(0, 1); cyc(5);
        chk("R3 low-first H", int'(pair_h), 5);
        chk("R3 low-first L", int'(pair_l), 3);
        disarm();
    endtask

    task automatic t_edge_arm_mid();
        mode = 2'd1; start_low = 1'b0; gate_in = 1'b1; cyc(5);
        arm = 1'b1; cyc(3);
        phase(1, 3); phase(0, 2);
        chk("R2 no write while waiting", n_rec, 0);
        phase(1, 4); phase(0, 2); phase(1, 1); phase(0, 0); cyc(5);
        chk("R5 write count", n_rec, 3);
        chk("R5 first count", int'(rec_d[0]), 4);
        chk("R5 first high tag", int'(rec_h[0]), 1);
        chk("R5 second count", int'(rec_d[1]), 2);
        chk("R5 second low tag", int'(rec_h[1]), 0);
        chk("R5 third count", int'(rec_d[2]), 1);
        disarm();
    endtask

    task automatic t_sampled();
        mode = 2'd2; start_low = 1'b0; gate_in = 1'b0; cyc(5);
        arm = 1'b1; cyc(3);
        sample();
        chk("R6 no write before pulse", n_rec, 0);
        phase(1, 4); phase(0, 2); phase(1, 6);
        sample(); sample();
        phase(0, 2); phase(1, 0);
        sample(); cyc(3);
        chk("R6 write count", n_rec, 3);
        chk("R6 first pair", int'(rec_d[0]), (4 << W) | 2);
        chk("R7 first fresh", int'(rec_r[0]), 0);
        chk("R7 second repeat", int'(rec_r[1]), 1);
        chk("R6 second pair", int'(rec_d[1]), (4 << W) | 2);
        chk("R6 third pair", int'(rec_d[2]), (6 << W) | 2);
        chk("R7 third fresh", int'(rec_r[2]), 0);
        disarm();
    endtask

    task automatic t_saturate();
        mode = 2'd1; start_low = 1'b0; gate_in = 1'b0; cyc(5);
        arm = 1'b1; cyc(3);
        phase(1, 35); phase(0, 2); phase(1, 0); cyc(5);
        chk("R8 saturated count", int'(rec_d[0]), 31);
        chk("R8 sat_flag", int'(sat_flag), 1);
        chk("R8 next phase count", int'(rec_d[1]), 2);
        disarm();
        chk("R10 disarm sat_flag", int'(sat_flag), 0);
    endtask

    task automatic t_overrun();
        mode = 2'd1; start_low = 1'b0; gate_in = 1'b0; fifo_full = 1'b1; cyc(5);
        arm = 1'b1; cyc(3);
        phase(1, 2); phase(0, 1); cyc(5);
        chk("R9 dropped write", n_rec, 0);
        chk("R9 overrun_flag", int'(overrun_flag), 1);
        fifo_full = 1'b0;
        phase(1, 0); cyc(5);
        chk("R9 write after full clears", n_rec, 1);
        chk("R9 written low count", int'(rec_d[0]), 1);
        chk("R9 overrun sticky", int'(overrun_flag), 1);
        disarm();
        chk("R10 disarm overrun_flag", int'(overrun_flag), 0);
    endtask

    initial begin
        cyc(4);
        rst = 1'b0;
        cyc(2);
        t_reset();
        t_single_high_first();
        t_start_low();
        t_edge_arm_mid();
        t_sampled();
        t_saturate();
        t_overrun();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule